// File: doc/BRIEF.md
# Round-Robin Interleaved Parallel Datapath

This block accepts one operand word per clock and hands consecutive words to N identical copies of a combinational function in strict rotation. A phase ring of N one-hot enables decides which copy captures the word in a given cycle. Each copy therefore takes a new operand only once every N cycles, so its logic has N full cycles to settle. A full-rate N-to-1 selector, followed by one output register, gathers the copies' results back into a single stream with one result per cycle, in the same order as the inputs.

The function in each copy is a placeholder picked by a parameter. The default multiplies the upper half of the word by the lower half and adds a constant bias. The alternative squares the upper half and adds the lower half. Enables stand in for divided clocks. The phase ring runs freely from reset, so a cycle without a valid word still uses up its slot. With N_LANES = 1 the block collapses to a single registered copy of the function.

Top module: `rr_interleave_dp`

## Requirements
- R1: `phase_oh` always has exactly one bit set, and during and directly after reset that bit is bit 0.
- R2: After each clock edge with reset low, the active phase moves from bit k to bit k+1, and from bit N_LANES-1 back to bit 0.
- R3: A word taken at a clock edge with `in_valid` high produces `out_valid` high exactly N_LANES clock edges later. Results leave in the order their words arrived.
- R4: Each result equals the reference function of its own word. For the default function, with a = `in_data[15:8]` and b = `in_data[7:0]`, the 17-bit result is a*b + 0xFFF0, and bit 16 carries the overflow.
- R5: A cycle with `in_valid` low gives `out_valid` low N_LANES edges later. In that cycle `out_data` keeps its previous value whatever `in_data` held.
- R6: Reset clears `out_valid` and `out_data` to zero and discards every word still in flight. No result for a word taken before reset ever appears afterwards.
- R7: An unbroken stream of valid words produces an unbroken stream of valid results at one per cycle. A copy's result is not disturbed when the same copy reloads at the edge where its result is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand word present this cycle |
| in_data | input | IN_W | Operand word; upper half a, lower half b |
| out_valid | output | 1 | Registered result present |
| out_data | output | IN_W+1 | Registered result |
| phase_oh | output | N_LANES | One-hot phase enables; bit k loads copy k |

## Verification
At a single clock edge, the active copy captures a new operand while the output register takes that same copy's previous result. Back-to-back valid streams make this happen at every edge. It is judged by requiring each output to match the word that arrived N_LANES cycles earlier, and never the word arriving now. Streams with gaps, bursts of corner operands and a reset in mid-flight then show that slot ordering, data hold and flushing still hold while this overlap is taking place.

// File: rtl/rr_dp_pkg.sv
package rr_dp_pkg;

  typedef enum logic [0:0] {
    FN_MAC   = 1'b0,
    FN_SQADD = 1'b1
  } func_kind_e;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rr_phase_gen.sv
module rr_phase_gen #(
  parameter int N_LANES = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  output logic [N_LANES-1:0] phase_oh,
  output logic [SEL_W-1:0]   sel
);

  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(N_LANES - 1);

  generate
    if (N_LANES == 1) begin : g_single
      always_ff @(posedge clk) begin
        phase_oh <= 1'b1;
        sel      <= '0;
      end
    end else begin : g_ring
      always_ff @(posedge clk) begin
        if (rst) begin
          phase_oh <= N_LANES'(1);
          sel      <= '0;
        end else begin
          phase_oh <= (phase_oh << 1) | (phase_oh >> (N_LANES - 1));
          sel      <= (sel == LAST_IDX) ? '0 : sel + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/rr_lane_slice.sv
module rr_lane_slice
  import rr_dp_pkg::*;
#(
  parameter int              IN_W = 16,
  parameter func_kind_e      FUNC = FN_MAC,
  parameter logic [IN_W-1:0] BIAS = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  output logic            res_valid,
  output logic [IN_W:0]   res_data
);

  localparam int HALF  = IN_W / 2;
  localparam int OUT_W = IN_W + 1;

  logic            op_v;
  logic [IN_W-1:0] op_d;
  logic [OUT_W-1:0] opa, opb;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_v <= 1'b0;
      op_d <= '0;
    end else if (load) begin
      op_v <= in_valid;
      op_d <= in_data;
    end
  end

  assign opa = OUT_W'(op_d[IN_W-1:HALF]);
  assign opb = OUT_W'(op_d[HALF-1:0]);

  generate
    if (FUNC == FN_MAC) begin : g_mac
      assign res_data = opa * opb + OUT_W'(BIAS);
    end else begin : g_sqadd
      assign res_data = opa * opa + opb;
    end
  endgenerate

  assign res_valid = op_v;

endmodule

// File: rtl/rr_out_merge.sv
module rr_out_merge #(
  parameter int N_LANES = 4,
  parameter int W       = 17,
  parameter int SEL_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SEL_W-1:0]           sel,
  input  logic [N_LANES-1:0]         lane_v,
  input  logic [N_LANES-1:0][W-1:0]  lane_d,
  output logic                       out_valid,
  output logic [W-1:0]               out_data
);

  logic         pick_v;
  logic [W-1:0] pick_d;

  always_comb begin
    pick_v = 1'b0;
    pick_d = '0;
    for (int k = 0; k < N_LANES; k++) begin
      if (sel == SEL_W'(k)) begin
        pick_v = lane_v[k];
        pick_d = lane_d[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pick_v;
      if (pick_v) out_data <= pick_d;
    end
  end

endmodule

// File: rtl/rr_interleave_dp.sv
module rr_interleave_dp
  import rr_dp_pkg::*;
#(
  parameter int              N_LANES = 4,
  parameter int              IN_W    = 16,
  parameter func_kind_e      FUNC    = FN_MAC,
  parameter logic [IN_W-1:0] BIAS    = 16'hFFF0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [IN_W-1:0]    in_data,
  output logic               out_valid,
  output logic [IN_W:0]      out_data,
  output logic [N_LANES-1:0] phase_oh
);

  localparam int OUT_W = IN_W + 1;
  localparam int SEL_W = sel_width(N_LANES);

  logic [SEL_W-1:0]              ph_sel;
  logic [N_LANES-1:0]            lane_v;
  logic [N_LANES-1:0][OUT_W-1:0] lane_d;

  rr_phase_gen #(.N_LANES(N_LANES), .SEL_W(SEL_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .phase_oh (phase_oh),
    .sel      (ph_sel)
  );

  generate
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
      rr_lane_slice #(.IN_W(IN_W), .FUNC(FUNC), .BIAS(BIAS)) u_lane (
        .clk       (clk),
        .rst       (rst),
        .load      (phase_oh[k]),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .res_valid (lane_v[k]),
        .res_data  (lane_d[k])
      );
    end
  endgenerate

  rr_out_merge #(.N_LANES(N_LANES), .W(OUT_W), .SEL_W(SEL_W)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .sel       (ph_sel),
    .lane_v    (lane_v),
    .lane_d    (lane_d),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/rr_interleave_dp_chk.sv
module rr_interleave_dp_chk
  import rr_dp_pkg::*;
#(
  parameter int              N_LANES = 4,
  parameter int              IN_W    = 16,
  parameter func_kind_e      FUNC    = FN_MAC,
  parameter logic [IN_W-1:0] BIAS    = 16'hFFF0,
  parameter int              SEL_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [IN_W-1:0]    in_data,
  input logic               out_valid,
  input logic [IN_W:0]      out_data,
  input logic [N_LANES-1:0] phase_oh,
  input logic [SEL_W-1:0]   sel
);

  localparam int HALF  = IN_W / 2;
  localparam int OUT_W = IN_W + 1;

  logic [N_LANES:0]           dv;
  logic [N_LANES:0][IN_W-1:0] dd;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv <= '0;
      dd <= '0;
    end else begin
      dv[0] <= in_valid;
      dd[0] <= in_data;
      for (int i = 1; i <= N_LANES; i++) begin
        dv[i] <= dv[i-1];
        dd[i] <= dd[i-1];
      end
    end
  end

  function automatic logic [OUT_W-1:0] ref_fn(input logic [IN_W-1:0] w);
    logic [OUT_W-1:0] a, b;
    a = OUT_W'(w[IN_W-1:HALF]);
    b = OUT_W'(w[HALF-1:0]);
    if (FUNC == FN_MAC) return a * b + OUT_W'(BIAS);
    else                return a * a + b;
  endfunction

  function automatic logic [N_LANES-1:0] rotl(input logic [N_LANES-1:0] x);
    if (N_LANES == 1) return x;
    return (x << 1) | (x >> (N_LANES - 1));
  endfunction

  p_phase_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh) == 1);

  p_phase_rotate_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_oh == rotl($past(phase_oh)));

  p_sel_match_r2: assert property (@(posedge clk) disable iff (rst)
    phase_oh == (N_LANES'(1) << sel));

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid == dv[N_LANES]);

  p_result_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data == ref_fn(dd[N_LANES]));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_data == $past(out_data));

  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && phase_oh == N_LANES'(1)));

endmodule

bind rr_interleave_dp rr_interleave_dp_chk #(
  .N_LANES (N_LANES),
  .IN_W    (IN_W),
  .FUNC    (FUNC),
  .BIAS    (BIAS),
  .SEL_W   (SEL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .phase_oh  (phase_oh),
  .sel       (ph_sel)
);

// File: tb/tb_rr_interleave_dp.sv
module tb_rr_interleave_dp;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [16:0] out_data;
  logic [N-1:0] phase_oh;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic        hv [0:N];
  logic [15:0] hd [0:N];
  logic [16:0] last_d = '0;
  int          ph_exp = 0;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  rr_interleave_dp dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .phase_oh  (phase_oh)
  );

  function automatic logic [16:0] fexp(input logic [15:0] d);
    return 17'(d[15:8]) * 17'(d[7:0]) + 17'h0FFF0;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic next_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  // one clock: check outputs of the edge just past, then drive the next inputs
  task automatic step(input logic v, input logic [15:0] d, input logic r, input string tag);
    @(negedge clk);
    cyc++;
    check($countones(phase_oh) == 1, "R1", 32'(phase_oh), 32'(1 << ph_exp));
    check(phase_oh == N'(1 << ph_exp), "R2", 32'(phase_oh), 32'(1 << ph_exp));
    check(out_valid == hv[N], tag, 32'(out_valid), 32'(hv[N]));
    if (hv[N]) begin
      check(out_data == fexp(hd[N]), "R4", 32'(out_data), 32'(fexp(hd[N])));
      last_d = fexp(hd[N]);
    end else begin
      check(out_data == last_d, "R5", 32'(out_data), 32'(last_d));
    end
    rst      = r;
    in_valid = v;
    in_data  = d;
    for (int i = N; i > 0; i--) begin
      hv[i] = hv[i-1];
      hd[i] = hd[i-1];
    end
    hv[0] = v & ~r;
    hd[0] = d;
    if (r) begin
      for (int i = 0; i <= N; i++) hv[i] = 1'b0;
      last_d = '0;
      ph_exp = 0;
    end else begin
      ph_exp = (ph_exp + 1) % N;
    end
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < N + 1; i++) begin
      next_lf();
      step(1'b0, lf, 1'b0, tag);
    end
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 3; i++) step(1'b0, 16'h0000, 1'b1, "R6");
    @(negedge clk);
    check(phase_oh == N'(1), "R1", 32'(phase_oh), 32'd1);
    check(out_valid == 1'b0, "R6", 32'(out_valid), 32'd0);
    check(out_data == '0, "R6", 32'(out_data), 32'd0);
    step(1'b0, 16'h0000, 1'b0, "R6");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 40; i++) begin
      next_lf();
      step(1'b1, lf, 1'b0, "R7");
    end
    flush("R3");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 30; i++) begin
      next_lf();
      step((i % 3) != 0 && (i % 7) != 5, lf, 1'b0, "R5");
    end
    flush("R3");
  endtask

  task automatic t_corner();
    logic [15:0] pat [0:7];
    pat = '{16'hFFFF, 16'h0000, 16'hFF00, 16'h00FF, 16'h0101, 16'h8080, 16'hFF01, 16'h01FF};
    for (int i = 0; i < 8; i++) step(1'b1, pat[i], 1'b0, "R4");
    flush("R3");
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 3; i++) begin
      next_lf();
      step(1'b1, lf, 1'b0, "R6");
    end
    step(1'b1, 16'h1234, 1'b1, "R6");
    step(1'b1, 16'h5678, 1'b1, "R6");
    for (int i = 0; i < N + 3; i++) step(1'b0, 16'hBEEF, 1'b0, "R6");
    for (int i = 0; i < 6; i++) begin
      next_lf();
      step(1'b1, lf, 1'b0, "R3");
    end
    flush("R3");
  endtask

  initial begin
    for (int i = 0; i <= N; i++) begin
      hv[i] = 1'b0;
      hd[i] = '0;
    end
    t_reset_state();
    t_stream();
    t_gaps();
    t_corner();
    t_midreset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule